// File: doc/BRIEF.md
# Data Flash External Access Controller

This block sits between an 8-bit microcontroller core and a 64 KB on-chip data flash array. It turns the core's external-data read and write strobes into flash array accesses when the data flash is mapped into external data space, and forwards them unchanged to the external bus interface when it is not. A read address comes from one of two sources. The first is the full 16-bit data pointer. The second is an auxiliary high-byte register joined with an 8-bit indirect low byte, and this second path can only read.

The block also issues the in-system-programming commands: byte program, page erase and chip erase. For byte program and page erase, address bit 16 comes from a bank-select control bit, so that the command reaches either the data flash or the program flash. For chip erase, the lock state decides whether the service region is kept. When the chip-protect state is active, every data flash read returns zero. A busy flag covers each flash operation from the accepting edge until the flash model reports completion.

Top module: `dflash_xbridge`

## Requirements
- R1: With enable set and `srcSel`=0, a read request drives one flash read with `flAddr` = {1, `ptrAddr`}, then pulses `rdValid` for one cycle with `rdData` equal to the byte the array returned.
- R2: With enable set and `srcSel`=1, the read address is {auxiliary register, `idxLow`}, and `flAddr` bit 16 is 1.
- R3: While enable is set, a write request on either address source causes no flash strobe and no external write strobe.
- R4: `ctlData` bit 0 is the enable bit and resets to 0. While it is 0, read and write requests appear combinationally on `extRdStb`/`extWrStb`, with `extAddr` set to the formed address and `extWrData` set to `wrData`, and no flash read strobe is issued.
- R5: When `protectOn` is high at the edge where the flash reports completion, the `rdData` that follows is 0x00.
- R6: `cmdOp` 01 is byte program and 10 is page erase. Each drives `flAddr` = {bank bit, `cmdAddr`}, where `ctlData` bit 1 is the bank bit (1 selects data flash, 0 selects program flash). Byte program also drives `flWrData` = `cmdData`.
- R7: `cmdOp` 11 pulses `flChipErStb`, with `flKeepIsp` equal to `lockOn` at the accepting edge.
- R8: Each flash strobe is high for exactly one cycle per accepted operation, and no two strobes are high together.
- R9: `busy` rises on the edge that accepts a read or command and falls on the edge that sees `flDone`. Read and command requests that arrive while `busy` is high are dropped.
- R10: The auxiliary register resets to 0x00, loads `auxWrData` on `auxWr`, and is visible on `auxRdData` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRd | input | 1 | Core external-data read request |
| reqWr | input | 1 | Core external-data write request |
| srcSel | input | 1 | Address source: 0 pointer, 1 aux+indirect |
| ptrAddr | input | 16 | 16-bit data pointer |
| idxLow | input | 8 | Indirect low byte |
| wrData | input | 8 | Core write data |
| rdData | output | 8 | Flash read data |
| rdValid | output | 1 | Read data valid pulse |
| busy | output | 1 | Flash operation in progress |
| auxWr | input | 1 | Auxiliary register write strobe |
| auxWrData | input | 8 | Auxiliary register write value |
| auxRdData | output | 8 | Auxiliary register readback |
| ctlWr | input | 1 | Control register write strobe |
| ctlData | input | 2 | bit0 enable, bit1 bank select |
| cmdValid | input | 1 | Programming command request |
| cmdOp | input | 2 | 01 program, 10 page erase, 11 chip erase |
| cmdAddr | input | 16 | Command address |
| cmdData | input | 8 | Program data byte |
| protectOn | input | 1 | Chip-protect state |
| lockOn | input | 1 | Service-region lock state |
| flAddr | output | 17 | Flash array address |
| flWrData | output | 8 | Flash program data |
| flRdStb | output | 1 | Flash read strobe |
| flPrgStb | output | 1 | Flash byte program strobe |
| flPgErStb | output | 1 | Flash page erase strobe |
| flChipErStb | output | 1 | Flash chip erase strobe |
| flKeepIsp | output | 1 | Keep service region during chip erase |
| flRdData | input | 8 | Flash array read data |
| flDone | input | 1 | Flash operation complete |
| extRdStb | output | 1 | External bus read strobe |
| extWrStb | output | 1 | External bus write strobe |
| extAddr | output | 16 | External bus address |
| extWrData | output | 8 | External bus write data |

## Verification
If the sequencer gets stuck outside idle, `busy` stays high and every later request is dropped. The next read then shows no `rdValid` within a few cycles. If the enable bit or the bank bit is stored wrongly, the mistake shows in the same cycle: a request goes to the external strobes when it should go to the flash, or the reverse, or flash address bit 16 is wrong on the strobe cycle that follows acceptance. A wrong captured byte or a missed protect mask shows on `rdData` in the single cycle where `rdValid` is high.

// File: rtl/dfx_pkg.sv
package dfx_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_PGER = 2'b10,
    OP_CHIP = 2'b11
  } dfx_op_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldRd;   // latch read address
    logic ldCmd;  // latch command address, data and lock
    logic capRd;  // capture array data
  } dfx_strb_t;
endpackage

// File: rtl/dfx_ctrl.sv
module dfx_ctrl
  import dfx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqRd,
  input  logic      cmdValid,
  input  logic [1:0] cmdOp,
  input  logic      dfEn,
  input  logic      flDone,
  output dfx_strb_t strb,
  output logic      flRdStb,
  output logic      flPrgStb,
  output logic      flPgErStb,
  output logic      flChipErStb,
  output logic      rdValid,
  output logic      busy
);
  typedef enum logic [1:0] {S_IDLE, S_RDWAIT, S_CMDWAIT} state_e;
  state_e state, stateNxt;
  logic acceptRd, acceptCmd;

  always_comb begin
    acceptRd   = (state == S_IDLE) && reqRd && dfEn;
    acceptCmd  = (state == S_IDLE) && cmdValid && (cmdOp != OP_NONE) && !acceptRd;
    strb.ldRd  = acceptRd;
    strb.ldCmd = acceptCmd;
    strb.capRd = (state == S_RDWAIT) && flDone;
    stateNxt   = state;
    unique case (state)
      S_IDLE: begin
        if (acceptRd)       stateNxt = S_RDWAIT;
        else if (acceptCmd) stateNxt = S_CMDWAIT;
      end
      S_RDWAIT:  if (flDone) stateNxt = S_IDLE;
      S_CMDWAIT: if (flDone) stateNxt = S_IDLE;
      default:   stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      flRdStb     <= 1'b0;
      flPrgStb    <= 1'b0;
      flPgErStb   <= 1'b0;
      flChipErStb <= 1'b0;
      rdValid     <= 1'b0;
    end else begin
      state       <= stateNxt;
      flRdStb     <= acceptRd;
      flPrgStb    <= acceptCmd && (cmdOp == OP_PROG);
      flPgErStb   <= acceptCmd && (cmdOp == OP_PGER);
      flChipErStb <= acceptCmd && (cmdOp == OP_CHIP);
      rdValid     <= strb.capRd;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/dfx_dpath.sv
module dfx_dpath
  import dfx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dfx_strb_t           strb,
  input  logic                srcSel,
  input  logic [ADDR_W-1:0]   ptrAddr,
  input  logic [ADDR_W/2-1:0] idxLow,
  input  logic                reqRd,
  input  logic                reqWr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                auxWr,
  input  logic [ADDR_W-ADDR_W/2-1:0] auxWrData,
  input  logic                ctlWr,
  input  logic [1:0]          ctlData,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdData,
  input  logic                lockOn,
  input  logic                protectOn,
  input  logic [DATA_W-1:0]   flRdData,
  output logic                dfEn,
  output logic [ADDR_W-ADDR_W/2-1:0] auxRdData,
  output logic [ADDR_W:0]     flAddr,
  output logic [DATA_W-1:0]   flWrData,
  output logic                flKeepIsp,
  output logic [DATA_W-1:0]   rdData,
  output logic                extRdStb,
  output logic                extWrStb,
  output logic [ADDR_W-1:0]   extAddr,
  output logic [DATA_W-1:0]   extWrData
);
  localparam int LOW_W  = ADDR_W / 2;
  localparam int HIGH_W = ADDR_W - LOW_W;

  logic [HIGH_W-1:0] auxQ;
  logic              enQ, bankQ;
  logic [ADDR_W-1:0] formedAddr;

  // control and auxiliary registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxQ  <= '0;
      enQ   <= 1'b0;
      bankQ <= 1'b0;
    end else begin
      if (auxWr) auxQ <= auxWrData;
      if (ctlWr) begin
        enQ   <= ctlData[0];
        bankQ <= ctlData[1];
      end
    end
  end

  assign formedAddr = srcSel ? {auxQ, idxLow} : ptrAddr;

  // flash-side address, data and erase qualifier
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flAddr    <= '0;
      flWrData  <= '0;
      flKeepIsp <= 1'b0;
    end else if (strb.ldRd) begin
      flAddr <= {1'b1, formedAddr};
    end else if (strb.ldCmd) begin
      flAddr    <= {bankQ, cmdAddr};
      flWrData  <= cmdData;
      flKeepIsp <= lockOn;
    end
  end

  // captured read data with protect mask
  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.capRd) rdData <= protectOn ? '0 : flRdData;
  end

  // unmapped accesses go straight out
  assign extRdStb  = reqRd && !enQ;
  assign extWrStb  = reqWr && !enQ;
  assign extAddr   = formedAddr;
  assign extWrData = wrData;
  assign dfEn      = enQ;
  assign auxRdData = auxQ;
endmodule

// File: rtl/dflash_xbridge.sv
module dflash_xbridge
  import dfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqRd,
  input  logic        reqWr,
  input  logic        srcSel,
  input  logic [15:0] ptrAddr,
  input  logic [7:0]  idxLow,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        busy,
  input  logic        auxWr,
  input  logic [7:0]  auxWrData,
  output logic [7:0]  auxRdData,
  input  logic        ctlWr,
  input  logic [1:0]  ctlData,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [15:0] cmdAddr,
  input  logic [7:0]  cmdData,
  input  logic        protectOn,
  input  logic        lockOn,
  output logic [16:0] flAddr,
  output logic [7:0]  flWrData,
  output logic        flRdStb,
  output logic        flPrgStb,
  output logic        flPgErStb,
  output logic        flChipErStb,
  output logic        flKeepIsp,
  input  logic [7:0]  flRdData,
  input  logic        flDone,
  output logic        extRdStb,
  output logic        extWrStb,
  output logic [15:0] extAddr,
  output logic [7:0]  extWrData
);
  dfx_strb_t strb;
  logic      dfEn;

  dfx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqRd(reqRd), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .dfEn(dfEn), .flDone(flDone), .strb(strb), .flRdStb(flRdStb),
    .flPrgStb(flPrgStb), .flPgErStb(flPgErStb), .flChipErStb(flChipErStb),
    .rdValid(rdValid), .busy(busy)
  );

  dfx_dpath #(.ADDR_W(16), .DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcSel(srcSel), .ptrAddr(ptrAddr),
    .idxLow(idxLow), .reqRd(reqRd), .reqWr(reqWr), .wrData(wrData),
    .auxWr(auxWr), .auxWrData(auxWrData), .ctlWr(ctlWr), .ctlData(ctlData),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .lockOn(lockOn), .protectOn(protectOn),
    .flRdData(flRdData), .dfEn(dfEn), .auxRdData(auxRdData), .flAddr(flAddr),
    .flWrData(flWrData), .flKeepIsp(flKeepIsp), .rdData(rdData),
    .extRdStb(extRdStb), .extWrStb(extWrStb), .extAddr(extAddr),
    .extWrData(extWrData)
  );
endmodule

// File: rtl/dflash_xbridge_chk.sv
module dflash_xbridge_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       rdValid,
  input logic [7:0] rdData,
  input logic       protectOn,
  input logic       lockOn,
  input logic       flKeepIsp,
  input logic       flRdStb,
  input logic       flPrgStb,
  input logic       flPgErStb,
  input logic       flChipErStb,
  input logic       auxWr,
  input logic [7:0] auxWrData,
  input logic [7:0] auxRdData
);
  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flRdStb, flPrgStb, flPgErStb, flChipErStb}));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    flRdStb |=> !flRdStb);
  assert_prg_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    flPrgStb |=> !flPrgStb);
  assert_pger_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    flPgErStb |=> !flPgErStb);
  assert_chip_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    flChipErStb |=> !flChipErStb);
  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flRdStb || flPrgStb || flPgErStb || flChipErStb) |-> busy);
  assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busy);
  assert_protect_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(protectOn)) |-> (rdData == 8'h00));
  assert_keep_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    flChipErStb |-> (flKeepIsp == $past(lockOn)));
  assert_aux_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(auxWr) |-> (auxRdData == $past(auxWrData)));
endmodule

bind dflash_xbridge dflash_xbridge_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .rdValid(rdValid), .rdData(rdData),
  .protectOn(protectOn), .lockOn(lockOn), .flKeepIsp(flKeepIsp),
  .flRdStb(flRdStb), .flPrgStb(flPrgStb), .flPgErStb(flPgErStb),
  .flChipErStb(flChipErStb), .auxWr(auxWr), .auxWrData(auxWrData),
  .auxRdData(auxRdData)
);

// File: tb/sim_dflash_xbridge.sv
module sim_dflash_xbridge;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqRd = 0, reqWr = 0, srcSel = 0, auxWr = 0, ctlWr = 0, cmdValid = 0;
  logic protectOn = 0, lockOn = 0;
  logic [15:0] ptrAddr = '0, cmdAddr = '0;
  logic [7:0]  idxLow = '0, wrData = '0, auxWrData = '0, cmdData = '0;
  logic [1:0]  ctlData = '0, cmdOp = '0;
  logic [7:0]  rdData, auxRdData, flWrData, flRdData, extWrData;
  logic        rdValid, busy, flRdStb, flPrgStb, flPgErStb, flChipErStb, flKeepIsp;
  logic        flDone, extRdStb, extWrStb;
  logic [16:0] flAddr;
  logic [15:0] extAddr;

  always #(CLK_NS/2) clk = ~clk;

  dflash_xbridge u0 (.*);

  function automatic logic [7:0] fdata(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
  endfunction
  assign flRdData = fdata(flAddr);

  // flash and bus model
  int unsigned pend = 0;
  int rdCnt = 0, prgCnt = 0, pgErCnt = 0, chipCnt = 0, extRdCnt = 0, extWrCnt = 0;
  logic [16:0] lastFlAddr = '0;
  logic [7:0]  lastWrData = '0;
  logic        lastKeep = 0;
  logic [15:0] lastExtAddr = '0;
  logic [7:0]  lastExtData = '0;
  logic        doneQ = 0;
  assign flDone = doneQ;
  always @(posedge clk) begin
    doneQ <= (pend == 1);
    if (flRdStb || flPrgStb || flPgErStb || flChipErStb) begin
      pend <= 2;
      lastFlAddr <= flAddr;
      lastWrData <= flWrData;
      lastKeep <= flKeepIsp;
    end else if (pend != 0) pend <= pend - 1;
    rdCnt   <= rdCnt + int'(flRdStb);
    prgCnt  <= prgCnt + int'(flPrgStb);
    pgErCnt <= pgErCnt + int'(flPgErStb);
    chipCnt <= chipCnt + int'(flChipErStb);
    extRdCnt <= extRdCnt + int'(extRdStb);
    extWrCnt <= extWrCnt + int'(extWrStb);
    if (extRdStb || extWrStb) begin
      lastExtAddr <= extAddr;
      lastExtData <= extWrData;
    end
  end

  int nChk = 0, nBad = 0;
  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %0h expected %0h", rq, got, exp);
    end
  endtask

  task automatic setAux(input logic [7:0] v);
    @(negedge clk); auxWr = 1; auxWrData = v;
    @(negedge clk); auxWr = 0;
  endtask
  task automatic setCtl(input logic en, input logic bank);
    @(negedge clk); ctlWr = 1; ctlData = {bank, en};
    @(negedge clk); ctlWr = 0;
  endtask
  task automatic doRead(input logic s, input logic [15:0] p, input logic [7:0] l);
    @(negedge clk); srcSel = s; ptrAddr = p; idxLow = l; reqRd = 1;
    @(negedge clk); reqRd = 0;
    for (int i = 0; i < 20 && !rdValid; i++) @(negedge clk);
  endtask
  task automatic doWrite(input logic s, input logic [15:0] p, input logic [7:0] l,
                         input logic [7:0] d);
    @(negedge clk); srcSel = s; ptrAddr = p; idxLow = l; wrData = d; reqWr = 1;
    @(negedge clk); reqWr = 0;
    repeat (4) @(negedge clk);
  endtask
  task automatic doCmd(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cmdValid = 1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk); cmdValid = 0; cmdOp = 2'b00;
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
  endtask

  typedef struct packed {
    logic        src;
    logic [7:0]  aux;
    logic [15:0] ptr;
    logic [7:0]  low;
    logic        prot;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 16'h1234, 8'h00, 1'b0},
    '{1'b1, 8'hAB, 16'h0000, 8'hCD, 1'b0},
    '{1'b0, 8'h00, 16'hFFFF, 8'h00, 1'b0},
    '{1'b1, 8'h00, 16'h5555, 8'hFF, 1'b0},
    '{1'b0, 8'h00, 16'h8001, 8'h00, 1'b1},
    '{1'b1, 8'h7E, 16'h0000, 8'h11, 1'b1}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("R10 aux reset", auxRdData, 8'h00);
    chk("R9 busy reset", busy, 0);
    chk("R1 rdValid reset", rdValid, 0);

    // R4: enable off after reset, accesses go to external bus
    c0 = rdCnt; c1 = extRdCnt;
    setAux(8'h3A);
    chk("R10 aux readback", auxRdData, 8'h3A);
    doRead(1'b1, 16'h0000, 8'h44);
    chk("R4 ext read count", extRdCnt - c1, 1);
    chk("R4 ext read addr", lastExtAddr, 16'h3A44);
    chk("R4 no flash read", rdCnt - c0, 0);
    chk("R4 no rdValid", rdValid, 0);
    c1 = extWrCnt;
    doWrite(1'b0, 16'hBEEF, 8'h00, 8'h96);
    chk("R4 ext write count", extWrCnt - c1, 1);
    chk("R4 ext write addr", lastExtAddr, 16'hBEEF);
    chk("R4 ext write data", lastExtData, 8'h96);

    setCtl(1'b1, 1'b1);
    // table walk: R1 pointer reads, R2 indirect reads, R5 protect
    for (int k = 0; k < NV; k++) begin
      logic [15:0] ea;
      logic [7:0]  ed;
      setAux(VECS[k].aux);
      protectOn = VECS[k].prot;
      c0 = rdCnt;
      ea = VECS[k].src ? {VECS[k].aux, VECS[k].low} : VECS[k].ptr;
      ed = VECS[k].prot ? 8'h00 : fdata({1'b1, ea});
      doRead(VECS[k].src, VECS[k].ptr, VECS[k].low);
      chk(VECS[k].src ? "R2 valid" : "R1 valid", rdValid, 1);
      chk(VECS[k].prot ? "R5 masked data" : (VECS[k].src ? "R2 data" : "R1 data"), rdData, ed);
      chk(VECS[k].src ? "R2 addr" : "R1 addr", lastFlAddr, {1'b1, ea});
      chk("R8 one read strobe", rdCnt - c0, 1);
      @(negedge clk);
      chk("R1 rdValid pulse", rdValid, 0);
    end
    protectOn = 0;

    // R3: writes discarded while enabled
    c0 = prgCnt + pgErCnt + chipCnt + rdCnt; c1 = extWrCnt;
    doWrite(1'b1, 16'h0000, 8'h22, 8'h5A);
    doWrite(1'b0, 16'h4321, 8'h00, 8'hA5);
    chk("R3 no flash strobe", prgCnt + pgErCnt + chipCnt + rdCnt - c0, 0);
    chk("R3 no ext write", extWrCnt - c1, 0);

    // R6: bank bit selects data or program flash
    c0 = prgCnt;
    doCmd(2'b01, 16'h0F0F, 8'hC3);
    chk("R6 program count", prgCnt - c0, 1);
    chk("R6 program addr bank1", lastFlAddr, 17'h10F0F);
    chk("R6 program data", lastWrData, 8'hC3);
    setCtl(1'b1, 1'b0);
    c0 = pgErCnt;
    doCmd(2'b10, 16'h7700, 8'h00);
    chk("R6 page erase count", pgErCnt - c0, 1);
    chk("R6 page erase addr bank0", lastFlAddr, 17'h07700);

    // R7: chip erase keeps region per lock
    lockOn = 1; c0 = chipCnt;
    doCmd(2'b11, 16'h0000, 8'h00);
    chk("R7 chip erase count", chipCnt - c0, 1);
    chk("R7 keep with lock", lastKeep, 1);
    lockOn = 0;
    doCmd(2'b11, 16'h0000, 8'h00);
    chk("R7 no keep unlocked", lastKeep, 0);

    // R9: requests during busy are dropped
    setCtl(1'b1, 1'b1);
    c0 = rdCnt; c1 = prgCnt;
    @(negedge clk); srcSel = 0; ptrAddr = 16'h2468; reqRd = 1;
    @(negedge clk); reqRd = 0;
    chk("R9 busy after accept", busy, 1);
    ptrAddr = 16'h1357; reqRd = 1; cmdValid = 1; cmdOp = 2'b01;
    @(negedge clk); reqRd = 0; cmdValid = 0; cmdOp = 2'b00;
    for (int i = 0; i < 20 && !rdValid; i++) @(negedge clk);
    chk("R9 data of first read", rdData, fdata({1'b1, 16'h2468}));
    chk("R9 busy cleared", busy, 0);
    repeat (6) @(negedge clk);
    chk("R9 second read dropped", rdCnt - c0, 1);
    chk("R9 command dropped", prgCnt - c1, 0);

    summary();
  end
endmodule